// File: doc/BRIEF.md
# Write Authorisation Guard for a Serial Memory Command Decoder

This block sits between the command decoder of a three-wire serial memory and its write-cycle controller. At the end of every frame, the decoder presents a one-cycle strobe together with the decoded command and the number of serial clock edges counted since the start bit. From these, the guard decides whether a write-class command may go ahead. The write-class commands are single-word write, single-word erase, fill-all and clear-all.

The guard holds a program-enable latch. An enable command sets it and a disable command clears it. A write-class command is released to the write-cycle controller as a one-cycle go pulse only when two conditions hold. The latch must be set, and the clock count must equal exactly the length that command requires. An extra or missing clock edge therefore cancels the command. This includes the case where noise turns a disable frame into an erase of word zero.

A low-supply flag arrives from an analog detector in another clock domain and is synchronised here. While the synchronised flag is high, the latch is held clear and no write is released. If a write is already running when the flag rises, the controller is sent a one-cycle abort pulse. Reset also leaves the latch clear, so the host must send an enable command before any write.

Top module: `wag_guard`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `prog_en_o`, `write_go_o` and `abort_o` are all 0.
- R2: A strobe carrying the enable command (code 6) sets `prog_en_o` on the next clock edge. A strobe carrying the disable command (code 7) clears it on the next clock edge. For these two commands the clock count has no effect.
- R3: A write-class command is one of write (code 2), erase (code 3), fill-all (code 4) or clear-all (code 5). When such a command is strobed with the latch set, the synchronised low-supply flag low and a matching count, `write_go_o` is 1 for exactly the cycle after the strobe.
- R4: The required count is 1+2+ADDR_W+DATA_W for write and fill-all, which is 25 by default. It is 1+2+ADDR_W for erase and clear-all, which is 9 by default. Any other count, larger or smaller, gives no go pulse.
- R5: With the latch clear, no write-class command produces a go pulse, whatever its count.
- R6: `low_supply_i` passes through SYNC_STAGES flops (default 2). While the synchronised flag is high, the latch is cleared on every edge, enable commands have no effect and no go pulse is issued. After the flag falls, the latch stays clear until a new enable command arrives.
- R7: Read (code 1) and no-operation (code 0) strobes never produce a go pulse and leave the latch unchanged, whatever their count.
- R8: When the synchronised flag and `write_busy_i` become high together, `abort_o` is 1 for exactly one cycle, one edge later.
- R9: A disable frame that gains one extra clock and decodes as erase with count 10 produces no go pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid_i | input | 1 | One-cycle end-of-frame strobe |
| cmd_op_i | input | 3 | Decoded command code |
| clk_count_i | input | CNT_W | Serial clock edges counted from the start bit |
| low_supply_i | input | 1 | Asynchronous low-supply flag |
| write_busy_i | input | 1 | High while the write-cycle controller is programming |
| write_go_o | output | 1 | One-cycle permission to start the write |
| abort_o | output | 1 | One-cycle request to abandon a running write |
| prog_en_o | output | 1 | Program-enable latch state |

## Verification
Each write-class command is sent at its exact length, one edge short and one edge long. This separates a check that merely tests for "at least enough clocks" from a true equality test. The same frames are repeated with the latch cleared, and again under low supply, so that each of the three gates is shown to block the go pulse on its own. A sweep over every command code and every count from 7 to 27 is compared against a behavioural model. The sweep shows that read, no-operation, enable and disable ignore the count while write-class codes honour it. It also covers the noise-lengthened disable frame. Raising the low-supply flag during a busy write, and then releasing it, shows a single abort pulse and shows that the latch stays clear until the next enable.

// File: rtl/wag_pkg.sv
// Shared command codes and helpers for the write authorisation guard.
// Assumes the command decoder presents codes with this exact encoding.
package wag_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_READ  = 3'd1,
        OP_WRITE = 3'd2,
        OP_ERASE = 3'd3,
        OP_FILL  = 3'd4,
        OP_CLEAR = 3'd5,
        OP_WEN   = 3'd6,
        OP_WDIS  = 3'd7
    } wag_op_e;

    // True for commands that change memory cells.
    function automatic logic is_write_class(input wag_op_e op);
        return (op == OP_WRITE) || (op == OP_ERASE) ||
               (op == OP_FILL)  || (op == OP_CLEAR);
    endfunction

    // True for commands that carry a data field after the address.
    function automatic logic carries_data(input wag_op_e op);
        return (op == OP_WRITE) || (op == OP_FILL);
    endfunction

endpackage

// File: rtl/wag_sync.sv
// Multi-flop synchroniser for the asynchronous low-supply flag.
// Assumes STAGES >= 2. Reset drives the chain to 0, the normal-supply state.
module wag_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the flag through the chain of flops.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/wag_len_check.sv
// Frame length checker: flags a write-class command whose clock count equals
// exactly the length its format needs. Purely combinational.
module wag_len_check
    import wag_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8
) (
    input  wag_op_e          op_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             write_class_o,
    output logic             len_ok_o
);
    localparam int HDR_LEN  = 1 + 2 + ADDR_W;
    localparam int FULL_LEN = HDR_LEN + DATA_W;
    localparam logic [CNT_W-1:0] HDR_CNT  = CNT_W'(HDR_LEN);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FULL_LEN);

    logic [CNT_W-1:0] need;

    // Pick the required length and compare for equality.
    always_comb begin
        write_class_o = is_write_class(op_i);
        need          = carries_data(op_i) ? FULL_CNT : HDR_CNT;
        len_ok_o      = write_class_o && (count_i == need);
    end
endmodule

// File: rtl/wag_enable_latch.sv
// Program-enable latch. The force input overrides all else, then clear
// overrides set. Reset leaves it disabled.
module wag_enable_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic force_off_i,
    output logic en_o
);
    // Update the enable state with force > clear > set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)           en_o <= 1'b0;
        else if (force_off_i) en_o <= 1'b0;
        else if (clr_i)       en_o <= 1'b0;
        else if (set_i)       en_o <= 1'b1;
    end
endmodule

// File: rtl/wag_guard.sv
// Write authorisation guard. Takes the end-of-frame strobe from the command
// decoder and releases write-class commands only when the enable latch is set,
// supply is good and the clock count is exact. Also raises a one-cycle abort
// when low supply meets a running write.
// Assumes cmd_valid_i is a single-cycle strobe in the clk domain.
module wag_guard
    import wag_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 16,
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid_i,
    input  logic [2:0]       cmd_op_i,
    input  logic [CNT_W-1:0] clk_count_i,
    input  logic             low_supply_i,
    input  logic             write_busy_i,
    output logic             write_go_o,
    output logic             abort_o,
    output logic             prog_en_o
);
    wag_op_e op;
    logic    lv_sync;
    logic    is_wr;
    logic    len_ok;
    logic    set_en;
    logic    clr_en;
    logic    go_d;
    logic    hazard;
    logic    hazard_q;

    assign op = wag_op_e'(cmd_op_i);

    wag_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (low_supply_i),
        .q_o   (lv_sync)
    );

    wag_len_check #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_len (
        .op_i          (op),
        .count_i       (clk_count_i),
        .write_class_o (is_wr),
        .len_ok_o      (len_ok)
    );

    // Decode enable/disable strobes and the go condition.
    always_comb begin
        set_en = cmd_valid_i && (op == OP_WEN);
        clr_en = cmd_valid_i && (op == OP_WDIS);
        go_d   = cmd_valid_i && is_wr && len_ok && prog_en_o && !lv_sync;
        hazard = lv_sync && write_busy_i;
    end

    wag_enable_latch u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_i       (set_en),
        .clr_i       (clr_en),
        .force_off_i (lv_sync),
        .en_o        (prog_en_o)
    );

    // Register the go pulse and edge-detect the abort hazard.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            write_go_o <= 1'b0;
            abort_o    <= 1'b0;
            hazard_q   <= 1'b0;
        end else begin
            write_go_o <= go_d;
            abort_o    <= hazard && !hazard_q;
            hazard_q   <= hazard;
        end
    end
endmodule

// File: rtl/wag_guard_chk.sv
// Assertion checker for wag_guard, attached with bind below.
module wag_guard_chk
    import wag_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid_i,
    input logic [2:0]       cmd_op_i,
    input logic [CNT_W-1:0] clk_count_i,
    input logic             lv_sync,
    input logic             write_go_o,
    input logic             abort_o,
    input logic             prog_en_o
);
    localparam int CHK_FULL = 3 + ADDR_W + DATA_W;
    localparam int CHK_HDR  = 3 + ADDR_W;

    // R5: a go pulse implies the latch was set at the strobe
    a_r5_go_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        write_go_o |-> $past(prog_en_o));

    // R4: wrong-length data-carrying command never goes
    a_r4_full_len_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && (cmd_op_i == 3'd2 || cmd_op_i == 3'd4) &&
         int'(clk_count_i) != CHK_FULL) |=> !write_go_o);

    // R4: wrong-length header-only command never goes
    a_r4_hdr_len_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && (cmd_op_i == 3'd3 || cmd_op_i == 3'd5) &&
         int'(clk_count_i) != CHK_HDR) |=> !write_go_o);

    // R6: low supply forces the latch clear and blocks go
    a_r6_low_clears: assert property (@(posedge clk) disable iff (!rst_n)
        lv_sync |=> (!prog_en_o && !write_go_o));

    // R7: non-write commands never go
    a_r7_no_go_other: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && (cmd_op_i < 3'd2 || cmd_op_i > 3'd5)) |=> !write_go_o);

    // R2: enable under good supply sets the latch
    a_r2_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_op_i == 3'd6 && !lv_sync) |=> prog_en_o);

    // R8: abort is a single-cycle pulse
    a_r8_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> !abort_o);
endmodule

bind wag_guard wag_guard_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .clk_count_i (clk_count_i),
    .lv_sync     (lv_sync),
    .write_go_o  (write_go_o),
    .abort_o     (abort_o),
    .prog_en_o   (prog_en_o)
);

// File: tb/wag_guard_tb.sv
`timescale 1ns/1ps
module wag_guard_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [7:0] clk_count = 8'd0;
    logic       low_supply = 1'b0;
    logic       write_busy = 1'b0;
    logic       write_go, abort, prog_en;

    int checks = 0;
    int errors = 0;
    int abort_seen = 0;
    string phase = "R1";

    // Behavioural reference state
    bit m_s1, m_s2, m_en, m_go, m_ab, m_hz;

    always #2.5 clk = ~clk;

    wag_guard u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
        .clk_count_i(clk_count), .low_supply_i(low_supply), .write_busy_i(write_busy),
        .write_go_o(write_go), .abort_o(abort), .prog_en_o(prog_en)
    );

    function automatic int need_len(int op);
        if (op == 2 || op == 4) return 25;
        if (op == 3 || op == 5) return 9;
        return -1;
    endfunction

    // Reference model advanced on every edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= 0; m_s2 <= 0; m_en <= 0; m_go <= 0; m_ab <= 0; m_hz <= 0;
        end else begin
            m_s1 <= low_supply;
            m_s2 <= m_s1;
            if (m_s2) m_en <= 0;
            else if (cmd_valid && cmd_op == 3'd7) m_en <= 0;
            else if (cmd_valid && cmd_op == 3'd6) m_en <= 1;
            m_go <= cmd_valid && !m_s2 && m_en && (int'(clk_count) == need_len(int'(cmd_op)));
            m_ab <= (m_s2 && write_busy) && !m_hz;
            m_hz <= m_s2 && write_busy;
        end
    end

    // Compare every cycle away from the active edge
    always @(negedge clk) begin
        checks++;
        if (write_go !== m_go || abort !== m_ab || prog_en !== m_en) begin
            errors++;
            $display("FAIL %s go/abort/en actual %b%b%b expected %b%b%b", phase,
                     write_go, abort, prog_en, m_go, m_ab, m_en);
        end
        if (abort === 1'b1) abort_seen++;
    end

    task automatic expect_bit(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b", tag, act, exp);
        end
    endtask

    // Send one frame strobe and check the go pulse one cycle later
    task automatic send(input int op, input int cnt, input int exp_go, input string tag);
        phase = tag;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'(op); clk_count = 8'(cnt);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (exp_go >= 0) expect_bit(write_go, 1'(exp_go), tag);
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired in phase %s", phase);
        summary();
        $finish;
    end

    initial begin
        phase = "R1";
        repeat (3) @(negedge clk);
        expect_bit(prog_en, 1'b0, "R1 en in reset");
        expect_bit(write_go, 1'b0, "R1 go in reset");
        rst_n = 1'b1;
        @(negedge clk);
        expect_bit(prog_en, 1'b0, "R1 en after reset");
        expect_bit(abort, 1'b0, "R1 abort after reset");

        send(2, 25, 0, "R5 write while disabled");
        send(6, 5, 0, "R2 enable odd count");
        expect_bit(prog_en, 1'b1, "R2 enable sets");
        send(2, 25, 1, "R3 write exact");
        send(4, 25, 1, "R3 fill exact");
        send(3, 9, 1, "R3 erase exact");
        send(5, 9, 1, "R3 clear exact");
        send(2, 24, 0, "R4 write short");
        send(2, 26, 0, "R4 write long");
        send(3, 8, 0, "R4 erase short");
        send(5, 25, 0, "R4 clear with data length");
        send(3, 10, 0, "R9 noisy disable as erase");
        send(1, 25, 0, "R7 read");
        send(0, 9, 0, "R7 none");
        expect_bit(prog_en, 1'b1, "R7 latch unchanged");
        send(7, 11, 0, "R2 disable");
        expect_bit(prog_en, 1'b0, "R2 disable clears");
        send(3, 9, 0, "R5 erase while disabled");

        send(6, 9, 0, "R6 enable before low");
        phase = "R8";
        write_busy = 1'b1; low_supply = 1'b1;
        repeat (5) @(negedge clk);
        expect_bit(prog_en, 1'b0, "R6 low clears latch");
        checks++;
        if (abort_seen != 1) begin
            errors++;
            $display("FAIL R8 abort pulses actual %0d expected 1", abort_seen);
        end
        write_busy = 1'b0;
        send(6, 9, 0, "R6 enable ignored in low");
        expect_bit(prog_en, 1'b0, "R6 enable ignored in low");
        send(2, 25, 0, "R6 write blocked in low");
        low_supply = 1'b0;
        repeat (4) @(negedge clk);
        expect_bit(prog_en, 1'b0, "R6 stays clear after release");
        send(6, 9, 0, "R6 re-enable");
        send(2, 25, 1, "R6 write after re-enable");

        for (int op = 0; op < 8; op++) begin
            for (int c = 7; c < 28; c++) begin
                send(6, 9, -1, "R4 sweep enable");
                send(op, c, -1, "R4 sweep");
            end
        end

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end
endmodule